// File: doc/BRIEF.md
# Fetch-Line Instruction Extractor with Branch Delay Slots

This block sits at the front of an instruction pipeline. Each thread owns a one-line buffer. When fetch is enabled for the selected thread, the block checks whether that thread's buffer holds the block containing the thread's fetch PC. On a hit it emits up to `FETCH_W` consecutive 32-bit instructions in the same cycle. Each emitted instruction carries its PC. On a miss it issues a line request for the aligned block address and emits nothing.

The ISA has branch delay slots, so the block keeps a current PC, a next PC, a pending delay-slot count and a recorded branch target for each thread. An external predictor supplies per-slot flags for each instruction in the emitted group: control, predicted taken, conditional delay slot and quiesce, plus a predicted target. The group walk follows these flags to decide where the group ends and where the thread resumes. When the instruction cache rejects a request, the block keeps it in a single shared retry slot. It then resends the request when the cache strobes retry.

Top module: `fetch_line_extract`

## Requirements
- R1: When the selected thread's line buffer is valid and its tag equals the fetch PC with the block-offset bits cleared, instructions are emitted and no request is issued.
- R2: On a miss, `req_o` rises in that same cycle with `req_addr_o` equal to the block-aligned fetch PC and `req_tid_o` equal to the thread. No instruction is emitted. The line buffer is invalidated and re-tagged until a fill arrives.
- R3: Slot k of a group carries the instruction at the slot's PC. The first slot's PC is the thread PC, word-aligned. Each sequential slot advances 4 bytes. The word at byte offset 4i of a line sits at bits [32i+31:32i] of the fill data.
- R4: A group ends at the last word of the block or after `FETCH_W` slots. The valid bits of a group are always contiguous from slot 0.
- R5: A non-control instruction sets the thread's next fetch PC to its own PC + 4.
- R6: A predicted-taken control instruction is followed by its delay-slot instruction at PC + 4. After that delay slot the group ends and the thread resumes at the predicted target.
- R7: When the predicted-taken branch is in the last slot of a group, the delay slot is fetched first in the next group. The group then ends and the thread resumes at the target.
- R8: A not-taken branch flagged as conditional-delay-slot skips its delay slot, so the next fetch is at PC + 8. An ordinary not-taken branch continues at PC + 4.
- R9: A quiesce instruction is emitted and ends the group. Its thread's bit in `quiesce_o` is set from the next cycle. After that the thread emits nothing and requests nothing, while other threads are unaffected.
- R10: While `interrupt_i` is high and the fetch PC's two low bits are 00, no new line request is issued. Hits still emit.
- R11: A request issued while `req_ready_i` is low is held in the retry slot with its thread, and `cache_blocked_o` is set from the next cycle. While blocked, no new request is issued. Each `retry_i` re-presents the held address and thread on the request port. Acceptance on a retry clears the slot and `cache_blocked_o` in the next cycle.
- R12: A `retry_i` strobe while the retry slot is empty issues no request and leaves `cache_blocked_o` low.
- R13: After reset, every line buffer is invalid, nothing is emitted or requested, `cache_blocked_o` and `quiesce_o` are zero. Thread t starts at `RESET_PC + t*THREAD_STRIDE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_en_i | input | 1 | Fetch the selected thread this cycle |
| tid_i | input | TID_W | Selected thread |
| interrupt_i | input | 1 | Interrupt pending, holds new requests |
| ctrl_i | input | FETCH_W | Per-slot: instruction is a control transfer |
| taken_i | input | FETCH_W | Per-slot: predicted taken |
| cds_i | input | FETCH_W | Per-slot: conditional-delay-slot branch |
| quiesce_i | input | FETCH_W | Per-slot: quiesce instruction |
| target_i | input | FETCH_W*32 | Per-slot predicted target, slot k at [32k+31:32k] |
| req_ready_i | input | 1 | Cache accepts the request presented this cycle |
| retry_i | input | 1 | Cache asks for the held request again |
| fill_valid_i | input | 1 | Line fill arrives |
| fill_tid_i | input | TID_W | Thread the fill belongs to |
| fill_data_i | input | BLOCK_BYTES*8 | Fill line data |
| req_o | output | 1 | Line request valid |
| req_addr_o | output | 32 | Block-aligned request address |
| req_tid_o | output | TID_W | Requesting thread |
| cache_blocked_o | output | 1 | Retry slot occupied, new requests held |
| inst_valid_o | output | FETCH_W | Per-slot instruction valid |
| inst_word_o | output | FETCH_W*32 | Per-slot instruction word |
| inst_pc_o | output | FETCH_W*32 | Per-slot instruction PC |
| quiesce_o | output | NUM_THREADS | Per-thread quiesced flag |

## Verification
The checks on the request port assume that every predicted target and reset PC is word-aligned. Under that assumption an interrupt pending always holds new requests. They also assume that a fill never arrives in the same cycle as a new request for the same thread. The cache never strobes retry and accepts a different request at once. The stimulus uses only aligned targets and drives fills only in cycles with fetch disabled. It places the delay slot after each predicted-taken branch as a plain instruction, so the pending count never exceeds one.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int AW    = 32;
  localparam int DSC_W = 2;

  typedef struct packed {
    logic [AW-1:0]    pc;
    logic [AW-1:0]    npc;
    logic [AW-1:0]    ds_tgt;
    logic [DSC_W-1:0] ds_cnt;
    logic             stop;
    logic             qsc;
  } fx_walk_t;
endpackage

// File: rtl/fx_line_buf.sv
module fx_line_buf #(
  parameter int NT     = 2,
  parameter int LINE_W = 128,
  parameter int AW     = 32,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_en_i,
  input  logic [TID_W-1:0]  inv_tid_i,
  input  logic [AW-1:0]     inv_tag_i,
  input  logic              fill_en_i,
  input  logic [TID_W-1:0]  fill_tid_i,
  input  logic [LINE_W-1:0] fill_data_i,
  input  logic [TID_W-1:0]  rd_tid_i,
  output logic              rd_valid_o,
  output logic [AW-1:0]     rd_tag_o,
  output logic [LINE_W-1:0] rd_data_o
);
  logic [NT-1:0]     vld_q;
  logic [AW-1:0]     tag_q  [NT];
  logic [LINE_W-1:0] data_q [NT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int t = 0; t < NT; t++) begin
        tag_q[t]  <= '0;
        data_q[t] <= '0;
      end
    end else begin
      for (int t = 0; t < NT; t++) begin
        if (inv_en_i && inv_tid_i == TID_W'(t)) begin
          vld_q[t] <= 1'b0;
          tag_q[t] <= inv_tag_i;
        end else if (fill_en_i && fill_tid_i == TID_W'(t)) begin
          vld_q[t]  <= 1'b1;
          data_q[t] <= fill_data_i;
        end
      end
    end
  end

  assign rd_valid_o = vld_q[rd_tid_i];
  assign rd_tag_o   = tag_q[rd_tid_i];
  assign rd_data_o  = data_q[rd_tid_i];
endmodule

// File: rtl/fx_retry_slot.sv
module fx_retry_slot #(
  parameter int AW    = 32,
  parameter int TID_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [AW-1:0]    cap_addr_i,
  input  logic [TID_W-1:0] cap_tid_i,
  input  logic             retry_i,
  input  logic             ack_i,
  output logic             full_o,
  output logic [AW-1:0]    addr_o,
  output logic [TID_W-1:0] tid_o,
  output logic             blocked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o    <= 1'b0;
      addr_o    <= '0;
      tid_o     <= '0;
      blocked_o <= 1'b0;
    end else if (cap_i) begin
      full_o    <= 1'b1;
      addr_o    <= cap_addr_i;
      tid_o     <= cap_tid_i;
      blocked_o <= 1'b1;
    end else if (retry_i) begin
      if (!full_o) begin
        blocked_o <= 1'b0;
      end else if (ack_i) begin
        full_o    <= 1'b0;
        blocked_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fx_group_walk.sv
module fx_group_walk import fx_pkg::*; #(
  parameter int FETCH_W     = 3,
  parameter int BLOCK_BYTES = 16,
  localparam int LINE_W     = BLOCK_BYTES * 8,
  localparam int OFF_W      = $clog2(BLOCK_BYTES)
) (
  input  logic                    en_i,
  input  fx_walk_t                start_i,
  input  logic [AW-1:0]           line_tag_i,
  input  logic [LINE_W-1:0]       line_data_i,
  input  logic [FETCH_W-1:0]      ctrl_i,
  input  logic [FETCH_W-1:0]      taken_i,
  input  logic [FETCH_W-1:0]      cds_i,
  input  logic [FETCH_W-1:0]      qsc_i,
  input  logic [FETCH_W*AW-1:0]   target_i,
  output logic [FETCH_W-1:0]      valid_o,
  output logic [FETCH_W*AW-1:0]   pc_o,
  output logic [FETCH_W*32-1:0]   word_o,
  output fx_walk_t                end_o
);
  localparam logic [AW-1:0] BLK_MASK = AW'(BLOCK_BYTES - 1);

  logic [FETCH_W-1:0][AW-1:0] slot_pc;

  // Slots are walked in order; each one sees the state left by the previous.
  always_comb begin
    fx_walk_t      cur;
    logic [AW-1:0] tgt;
    cur      = start_i;
    cur.stop = !en_i;
    cur.qsc  = 1'b0;
    for (int k = 0; k < FETCH_W; k++) begin
      tgt        = target_i[k*AW +: AW];
      slot_pc[k] = cur.pc;
      valid_o[k] = !cur.stop && ((cur.pc & ~BLK_MASK) == line_tag_i);
      if (!valid_o[k]) begin
        cur.stop = 1'b1;
      end else if (qsc_i[k]) begin
        cur.npc  = cur.pc + AW'(8);
        cur.pc   = cur.pc + AW'(4);
        cur.stop = 1'b1;
        cur.qsc  = 1'b1;
      end else if (ctrl_i[k] && taken_i[k]) begin
        cur.pc     = cur.npc;
        cur.npc    = tgt;
        cur.ds_cnt = cur.ds_cnt + DSC_W'(1);
        cur.ds_tgt = tgt;
      end else if (ctrl_i[k] && cds_i[k]) begin
        cur.npc = cur.pc + AW'(12);
        cur.pc  = cur.pc + AW'(8);
      end else if (ctrl_i[k]) begin
        cur.pc  = cur.npc;
        cur.npc = cur.npc + AW'(4);
      end else if (cur.ds_cnt != '0) begin
        if (cur.ds_cnt == DSC_W'(1)) begin
          cur.pc   = cur.ds_tgt;
          cur.npc  = cur.ds_tgt + AW'(4);
          cur.stop = 1'b1;
        end else begin
          cur.npc = cur.pc + AW'(8);
          cur.pc  = cur.pc + AW'(4);
        end
        cur.ds_cnt = cur.ds_cnt - DSC_W'(1);
      end else begin
        cur.npc = cur.pc + AW'(8);
        cur.pc  = cur.pc + AW'(4);
      end
    end
    end_o = cur;
  end

  for (genvar k = 0; k < FETCH_W; k++) begin : g_slot
    logic [OFF_W-3:0] idx;
    assign idx                 = slot_pc[k][OFF_W-1:2];
    assign pc_o[k*AW +: AW]    = slot_pc[k];
    assign word_o[k*32 +: 32]  = line_data_i[32*int'(idx) +: 32];
  end
endmodule

// File: rtl/fetch_line_extract.sv
module fetch_line_extract import fx_pkg::*; #(
  parameter int            NUM_THREADS   = 2,
  parameter int            FETCH_W       = 3,
  parameter int            BLOCK_BYTES   = 16,
  parameter logic [31:0]   RESET_PC      = 32'h0000_0100,
  parameter logic [31:0]   THREAD_STRIDE = 32'h0000_1000,
  localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int LINE_W = BLOCK_BYTES * 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fetch_en_i,
  input  logic [TID_W-1:0]      tid_i,
  input  logic                  interrupt_i,
  input  logic [FETCH_W-1:0]    ctrl_i,
  input  logic [FETCH_W-1:0]    taken_i,
  input  logic [FETCH_W-1:0]    cds_i,
  input  logic [FETCH_W-1:0]    quiesce_i,
  input  logic [FETCH_W*32-1:0] target_i,
  input  logic                  req_ready_i,
  input  logic                  retry_i,
  input  logic                  fill_valid_i,
  input  logic [TID_W-1:0]      fill_tid_i,
  input  logic [LINE_W-1:0]     fill_data_i,
  output logic                  req_o,
  output logic [31:0]           req_addr_o,
  output logic [TID_W-1:0]      req_tid_o,
  output logic                  cache_blocked_o,
  output logic [FETCH_W-1:0]    inst_valid_o,
  output logic [FETCH_W*32-1:0] inst_word_o,
  output logic [FETCH_W*32-1:0] inst_pc_o,
  output logic [NUM_THREADS-1:0] quiesce_o
);
  localparam logic [AW-1:0] BLK_MASK = AW'(BLOCK_BYTES - 1);

  logic [AW-1:0]    pc_q  [NUM_THREADS];
  logic [AW-1:0]    npc_q [NUM_THREADS];
  logic [AW-1:0]    tgt_q [NUM_THREADS];
  logic [DSC_W-1:0] cnt_q [NUM_THREADS];
  logic [NUM_THREADS-1:0] qsc_q;

  logic              lb_valid;
  logic [AW-1:0]     lb_tag;
  logic [LINE_W-1:0] lb_data;
  logic [AW-1:0]     cur_pc, blk_addr;
  logic              go, hit, irq_hold, miss_req, resend, commit;
  logic              slot_full;
  logic [AW-1:0]     slot_addr;
  logic [TID_W-1:0]  slot_tid;
  fx_walk_t          walk_start, walk_end;

  assign cur_pc   = pc_q[tid_i];
  assign blk_addr = cur_pc & ~BLK_MASK;
  assign go       = fetch_en_i && !qsc_q[tid_i];
  assign hit      = lb_valid && (lb_tag == blk_addr);
  assign irq_hold = interrupt_i && (cur_pc[1:0] == 2'b00);
  assign miss_req = go && !hit && !cache_blocked_o && !irq_hold;
  assign resend   = retry_i && slot_full;

  assign req_o      = resend || miss_req;
  assign req_addr_o = resend ? slot_addr : blk_addr;
  assign req_tid_o  = resend ? slot_tid  : tid_i;

  fx_line_buf #(.NT(NUM_THREADS), .LINE_W(LINE_W), .AW(AW)) u_line_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inv_en_i    (miss_req),
    .inv_tid_i   (tid_i),
    .inv_tag_i   (blk_addr),
    .fill_en_i   (fill_valid_i),
    .fill_tid_i  (fill_tid_i),
    .fill_data_i (fill_data_i),
    .rd_tid_i    (tid_i),
    .rd_valid_o  (lb_valid),
    .rd_tag_o    (lb_tag),
    .rd_data_o   (lb_data)
  );

  fx_retry_slot #(.AW(AW), .TID_W(TID_W)) u_retry (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (miss_req && !req_ready_i),
    .cap_addr_i (blk_addr),
    .cap_tid_i  (tid_i),
    .retry_i    (retry_i),
    .ack_i      (req_ready_i),
    .full_o     (slot_full),
    .addr_o     (slot_addr),
    .tid_o      (slot_tid),
    .blocked_o  (cache_blocked_o)
  );

  always_comb begin
    walk_start        = '0;
    walk_start.pc     = cur_pc;
    walk_start.npc    = npc_q[tid_i];
    walk_start.ds_tgt = tgt_q[tid_i];
    walk_start.ds_cnt = cnt_q[tid_i];
  end

  fx_group_walk #(.FETCH_W(FETCH_W), .BLOCK_BYTES(BLOCK_BYTES)) u_walk (
    .en_i        (go && hit),
    .start_i     (walk_start),
    .line_tag_i  (lb_tag),
    .line_data_i (lb_data),
    .ctrl_i      (ctrl_i),
    .taken_i     (taken_i),
    .cds_i       (cds_i),
    .qsc_i       (quiesce_i),
    .target_i    (target_i),
    .valid_o     (inst_valid_o),
    .pc_o        (inst_pc_o),
    .word_o      (inst_word_o),
    .end_o       (walk_end)
  );

  assign commit = inst_valid_o[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qsc_q <= '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
        pc_q[t]  <= RESET_PC + AW'(t) * THREAD_STRIDE;
        npc_q[t] <= RESET_PC + AW'(t) * THREAD_STRIDE + AW'(4);
        tgt_q[t] <= '0;
        cnt_q[t] <= '0;
      end
    end else if (commit) begin
      pc_q[tid_i]  <= walk_end.pc;
      npc_q[tid_i] <= walk_end.npc;
      tgt_q[tid_i] <= walk_end.ds_tgt;
      cnt_q[tid_i] <= walk_end.ds_cnt;
      qsc_q[tid_i] <= walk_end.qsc;
    end
  end

  assign quiesce_o = qsc_q;
endmodule

// File: rtl/fetch_line_extract_chk.sv
module fetch_line_extract_chk #(
  parameter int NUM_THREADS = 2,
  parameter int FETCH_W     = 3,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   fetch_en_i,
  input logic [TID_W-1:0]       tid_i,
  input logic                   interrupt_i,
  input logic                   req_ready_i,
  input logic                   retry_i,
  input logic                   req_o,
  input logic                   cache_blocked_o,
  input logic [FETCH_W-1:0]     inst_valid_o,
  input logic [NUM_THREADS-1:0] quiesce_o
);
  p_miss_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !cache_blocked_o |-> inst_valid_o == '0);

  p_contig_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((inst_valid_o + FETCH_W'(1)) & inst_valid_o) == '0);

  p_quiesce_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_i && quiesce_o[tid_i] |-> inst_valid_o == '0);

  p_quiesce_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiesce_o != '0 |=> (quiesce_o & $past(quiesce_o)) == $past(quiesce_o));

  p_irq_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interrupt_i && !cache_blocked_o |-> !req_o);

  p_blocked_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_blocked_o && !retry_i |-> !req_o);

  p_set_block_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !req_ready_i && !cache_blocked_o |=> cache_blocked_o);

  p_clear_block_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_blocked_o && retry_i && req_ready_i |=> !cache_blocked_o);
endmodule

bind fetch_line_extract fetch_line_extract_chk #(
  .NUM_THREADS (NUM_THREADS),
  .FETCH_W     (FETCH_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fetch_en_i      (fetch_en_i),
  .tid_i           (tid_i),
  .interrupt_i     (interrupt_i),
  .req_ready_i     (req_ready_i),
  .retry_i         (retry_i),
  .req_o           (req_o),
  .cache_blocked_o (cache_blocked_o),
  .inst_valid_o    (inst_valid_o),
  .quiesce_o       (quiesce_o)
);

// File: tb/fetch_line_extract_test.sv
`timescale 1ns/1ps
module fetch_line_extract_test;
  localparam int W  = 3;
  localparam int LW = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_en, tid, irq;
  logic [W-1:0]  ctrl, taken, cds, qsc;
  logic [W*32-1:0] target;
  logic          rdy, retry, fill_v, fill_tid;
  logic [LW-1:0] fill_data;
  logic          req_o, req_tid_o, cache_blocked_o;
  logic [31:0]   req_addr_o;
  logic [W-1:0]  inst_valid_o;
  logic [W*32-1:0] inst_word_o, inst_pc_o;
  logic [1:0]    quiesce_o;

  always #2.5 clk = ~clk;

  fetch_line_extract uut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_en_i(fetch_en), .tid_i(tid),
    .interrupt_i(irq), .ctrl_i(ctrl), .taken_i(taken), .cds_i(cds),
    .quiesce_i(qsc), .target_i(target), .req_ready_i(rdy), .retry_i(retry),
    .fill_valid_i(fill_v), .fill_tid_i(fill_tid), .fill_data_i(fill_data),
    .req_o(req_o), .req_addr_o(req_addr_o), .req_tid_o(req_tid_o),
    .cache_blocked_o(cache_blocked_o), .inst_valid_o(inst_valid_o),
    .inst_word_o(inst_word_o), .inst_pc_o(inst_pc_o), .quiesce_o(quiesce_o)
  );

  typedef struct packed {
    logic [7:0]       rid;
    logic [W-1:0]     v;
    logic [W-1:0][31:0] pc;
    logic             req;
    logic [31:0]      ra;
    logic             rt;
    logic             blk;
    logic [1:0]       qs;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   done = 1'b0;

  function automatic logic [31:0] mk(logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [LW-1:0] line(logic [31:0] b);
    logic [LW-1:0] d;
    for (int i = 0; i < LW/32; i++) d[i*32 +: 32] = mk(b + 32'(4*i));
    return d;
  endfunction

  task automatic clear_in();
    fetch_en = 0; tid = 0; irq = 0; ctrl = '0; taken = '0; cds = '0; qsc = '0;
    target = '0; rdy = 1; retry = 0; fill_v = 0; fill_tid = 0; fill_data = '0;
  endtask

  task automatic expect_cyc(input logic [7:0] rid, input logic [W-1:0] v,
                            input logic [31:0] p0, p1, p2, input logic rq,
                            input logic [31:0] ra, input logic rt,
                            input logic blk, input logic [1:0] qs);
    exp_t e;
    e.rid = rid; e.v = v; e.pc[0] = p0; e.pc[1] = p1; e.pc[2] = p2;
    e.req = rq; e.ra = ra; e.rt = rt; e.blk = blk; e.qs = qs;
    q.push_back(e);
  endtask

  task automatic step();
    @(posedge clk); #1;
    clear_in();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    exp_t e;
    bit bad;
    if (q.size() > 0) begin
      e = q.pop_front();
      bad = 0;
      if (inst_valid_o !== e.v) bad = 1;
      for (int k = 0; k < W; k++)
        if (e.v[k] && (inst_pc_o[k*32 +: 32] !== e.pc[k] ||
                       inst_word_o[k*32 +: 32] !== mk(e.pc[k]))) bad = 1;
      if (req_o !== e.req) bad = 1;
      if (e.req && (req_addr_o !== e.ra || req_tid_o !== e.rt)) bad = 1;
      if (cache_blocked_o !== e.blk || quiesce_o !== e.qs) bad = 1;
      n_chk++;
      if (bad) begin
        n_fail++;
        $display("FAIL R%0d: got v=%b pc=%h/%h/%h req=%b addr=%h tid=%b blk=%b q=%b; exp v=%b pc=%h/%h/%h req=%b addr=%h tid=%b blk=%b q=%b",
                 e.rid, inst_valid_o, inst_pc_o[31:0], inst_pc_o[63:32], inst_pc_o[95:64],
                 req_o, req_addr_o, req_tid_o, cache_blocked_o, quiesce_o,
                 e.v, e.pc[0], e.pc[1], e.pc[2], e.req, e.ra, e.rt, e.blk, e.qs);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got cycle %0d expected under 5000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    clear_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R13: reset state
    expect_cyc(13, 3'b000, 0, 0, 0, 0, 0, 0, 0, 2'b00); step();
    // R2: miss on thread 0 start PC
    fetch_en = 1;
    expect_cyc(2, 3'b000, 0, 0, 0, 1, 32'h100, 0, 0, 2'b00); step();
    fill_v = 1; fill_data = line(32'h100);
    expect_cyc(2, 3'b000, 0, 0, 0, 0, 0, 0, 0, 2'b00); step();
    // R1 R3 R5: hit, three sequential words
    fetch_en = 1;
    expect_cyc(1, 3'b111, 32'h100, 32'h104, 32'h108, 0, 0, 0, 0, 2'b00); step();
    // R4: block end limits group to one slot
    fetch_en = 1;
    expect_cyc(4, 3'b001, 32'h10C, 0, 0, 0, 0, 0, 0, 2'b00); step();
    fetch_en = 1;
    expect_cyc(2, 3'b000, 0, 0, 0, 1, 32'h110, 0, 0, 2'b00); step();
    fill_v = 1; fill_data = line(32'h110);
    expect_cyc(2, 3'b000, 0, 0, 0, 0, 0, 0, 0, 2'b00); step();
    // R6: taken branch, delay slot, then stop
    fetch_en = 1; ctrl = 3'b001; taken = 3'b001; target[31:0] = 32'h200;
    expect_cyc(6, 3'b011, 32'h110, 32'h114, 0, 0, 0, 0, 0, 2'b00); step();
    // R6 target reached / R11: request rejected
    fetch_en = 1; rdy = 0;
    expect_cyc(11, 3'b000, 0, 0, 0, 1, 32'h200, 0, 0, 2'b00); step();
    fetch_en = 1; rdy = 0;
    expect_cyc(11, 3'b000, 0, 0, 0, 0, 0, 0, 1, 2'b00); step();
    retry = 1; rdy = 0;
    expect_cyc(11, 3'b000, 0, 0, 0, 1, 32'h200, 0, 1, 2'b00); step();
    retry = 1; rdy = 1;
    expect_cyc(11, 3'b000, 0, 0, 0, 1, 32'h200, 0, 1, 2'b00); step();
    fill_v = 1; fill_data = line(32'h200);
    expect_cyc(11, 3'b000, 0, 0, 0, 0, 0, 0, 0, 2'b00); step();
    // R7: taken branch in last slot
    fetch_en = 1; ctrl = 3'b100; taken = 3'b100; target[95:64] = 32'h300;
    expect_cyc(7, 3'b111, 32'h200, 32'h204, 32'h208, 0, 0, 0, 0, 2'b00); step();
    fetch_en = 1;
    expect_cyc(7, 3'b001, 32'h20C, 0, 0, 0, 0, 0, 0, 2'b00); step();
    // R10: interrupt holds the miss request
    fetch_en = 1; irq = 1;
    expect_cyc(10, 3'b000, 0, 0, 0, 0, 0, 0, 0, 2'b00); step();
    fetch_en = 1;
    expect_cyc(10, 3'b000, 0, 0, 0, 1, 32'h300, 0, 0, 2'b00); step();
    fill_v = 1; fill_data = line(32'h300);
    expect_cyc(10, 3'b000, 0, 0, 0, 0, 0, 0, 0, 2'b00); step();
    // R8: cds not-taken skips, ordinary not-taken falls through; R10 hit under interrupt
    fetch_en = 1; irq = 1; ctrl = 3'b101; cds = 3'b001;
    expect_cyc(8, 3'b111, 32'h300, 32'h308, 32'h30C, 0, 0, 0, 0, 2'b00); step();
    // R2: thread 1 miss
    fetch_en = 1; tid = 1;
    expect_cyc(2, 3'b000, 0, 0, 0, 1, 32'h1100, 1, 0, 2'b00); step();
    fill_v = 1; fill_tid = 1; fill_data = line(32'h1100);
    expect_cyc(2, 3'b000, 0, 0, 0, 0, 0, 0, 0, 2'b00); step();
    // R9: quiesce emitted and ends group
    fetch_en = 1; tid = 1; qsc = 3'b010;
    expect_cyc(9, 3'b011, 32'h1100, 32'h1104, 0, 0, 0, 0, 0, 2'b00); step();
    fetch_en = 1; tid = 1;
    expect_cyc(9, 3'b000, 0, 0, 0, 0, 0, 0, 0, 2'b10); step();
    // R9: other thread still fetches (R8 fall-through PC 0x310)
    fetch_en = 1;
    expect_cyc(9, 3'b000, 0, 0, 0, 1, 32'h310, 0, 0, 2'b10); step();
    // R12: retry with empty slot
    retry = 1; rdy = 1;
    expect_cyc(12, 3'b000, 0, 0, 0, 0, 0, 0, 0, 2'b10); step();

    @(negedge clk); #1;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R13: scoreboard left %0d items, expected 0", q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule